// File: doc/BRIEF.md
# Condition Register Update Unit

This block owns a 32-bit condition register built from eight 4-bit fields and performs every write that can change it. Field 0 is the most significant nibble. Inside each field the bits are, from most to least significant: less-than (LT), greater-than (GT), equal (EQ) and summary-overflow (SO). The register can be updated at field granularity in four ways: from the sign of a result, from a compare result, after a conditional store, or by a masked bulk load. It can also be updated one bit at a time by a Boolean combination of two of its own bits.

A decoder outside the block raises one strobe per cycle and presents the operands for that operation. The summary-overflow flag comes from elsewhere and is merged into the field updates that call for it. The whole register is always visible on a read bus. A 5-bit index gives a single-bit read, using the same MSB-first bit numbering as the bit-logic operations.

Top module: `cr_unit`

## Requirements
- R1: While reset is low the register reads all zeros, whatever strobes are raised.
- R2: Bit index k (0..31) names word bit 31-k. `rd_bit` shows the bit that `rd_idx` names in the current register value, and `cr_word` shows the whole register. Field f occupies word bits 31-4f down to 28-4f.
- R3: Strobe bit 0 (sign update) writes field 0 as follows. If `res_val[31]` is set, the field is LT only (4'b1000). Otherwise a nonzero value gives GT only (4'b0100) and zero gives EQ only (4'b0010). In every case the SO bit then takes `sum_ovf`. No other field changes.
- R4: Strobe bit 1 (compare) writes `{cmp_val[3:1], sum_ovf}` into field `cmp_fld`. The other seven fields keep their values.
- R5: Strobe bit 2 (conditional store) writes field 0 as `{1'b0, 1'b0, st_ok, sum_ovf}`. The other fields keep their values.
- R6: Strobe bit 3 (bit logic) writes bit `bl_d` with f(bit `bl_a`, bit `bl_b`). Both operands are read from the value before the edge. `bl_func` codes: 0 AND, 1 OR, 2 XOR, 3 NAND, 4 NOR, 5 XNOR, 6 A AND NOT B, 7 A OR NOT B. All other bits keep their values.
- R7: Strobe bit 4 (field move) copies the pre-edge field `mv_src` into field `mv_dst`. All other fields keep their values.
- R8: Strobe bit 5 (masked load) gives each field f whose mask bit `ld_mask[7-f]` is set the nibble of `ld_val` at that field's position. Unselected fields keep their values, so a zero mask changes nothing.
- R9: With no strobe raised the register holds its value.
- R10: When several strobes are raised at once, only the lowest-numbered one takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_stb | input | 6 | One strobe per operation, bit order as in R3..R8 |
| sum_ovf | input | 1 | Current summary-overflow flag |
| res_val | input | 32 | Signed result for the sign update |
| cmp_fld | input | 3 | Destination field of a compare |
| cmp_val | input | 4 | Compare result nibble (bit 0 ignored) |
| st_ok | input | 1 | Conditional store succeeded |
| bl_func | input | 3 | Bit-logic function code |
| bl_a | input | 5 | First source bit index |
| bl_b | input | 5 | Second source bit index |
| bl_d | input | 5 | Destination bit index |
| mv_src | input | 3 | Field move source |
| mv_dst | input | 3 | Field move destination |
| ld_mask | input | 8 | Masked load field selector |
| ld_val | input | 32 | Masked load data |
| rd_idx | input | 5 | Single-bit read index |
| cr_word | output | 32 | Current register value |
| rd_bit | output | 1 | Bit selected by rd_idx |

## Verification
The collisions that matter most are two updates aimed at the same cycle: for example, a compare or sign update raised together with a masked load or bit-logic write that touches the same field. The bench provokes these both with directed cases (sign update plus full-mask load, compare plus field move) and with random multi-hot strobe patterns. It judges each one by applying only the lowest-numbered strobe in its own model. Bit-logic writes whose destination is also a source, and moves whose source and destination are the same field, check that operands are taken from the pre-edge value.

// File: rtl/cr_pkg.sv
package cr_pkg;
    localparam int FIELD_W  = 4;
    localparam int NUM_OPS  = 6;

    // strobe positions, lower index has priority
    localparam int OP_SIGN  = 0;
    localparam int OP_CMP   = 1;
    localparam int OP_STC   = 2;
    localparam int OP_BIT   = 3;
    localparam int OP_MOVE  = 4;
    localparam int OP_LOAD  = 5;

    // position of each flag inside a field
    localparam int POS_LT = 3;
    localparam int POS_GT = 2;
    localparam int POS_EQ = 1;
    localparam int POS_SO = 0;

    typedef enum logic [2:0] {
        BL_AND  = 3'd0,
        BL_OR   = 3'd1,
        BL_XOR  = 3'd2,
        BL_NAND = 3'd3,
        BL_NOR  = 3'd4,
        BL_XNOR = 3'd5,
        BL_ANDC = 3'd6,
        BL_ORC  = 3'd7
    } bl_func_e;
endpackage

// File: rtl/cr_sign_class.sv
module cr_sign_class
    import cr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]  value_i,
    input  logic               so_i,
    output logic [FIELD_W-1:0] field_o
);
    always_comb begin
        field_o = '0;
        if (value_i[DATA_W-1]) begin
            field_o[POS_LT] = 1'b1;
        end else if (value_i != '0) begin
            field_o[POS_GT] = 1'b1;
        end else begin
            field_o[POS_EQ] = 1'b1;
        end
        field_o[POS_SO] = so_i;
    end

    // R3
    sign_onehot_chk: assert final ($onehot(field_o[FIELD_W-1:1]));
endmodule

// File: rtl/cr_bit_logic.sv
module cr_bit_logic
    import cr_pkg::*;
(
    input  logic [2:0] func_i,
    input  logic       a_i,
    input  logic       b_i,
    output logic       y_o
);
    always_comb begin
        unique case (bl_func_e'(func_i))
            BL_AND:  y_o =   a_i & b_i;
            BL_OR:   y_o =   a_i | b_i;
            BL_XOR:  y_o =   a_i ^ b_i;
            BL_NAND: y_o = ~(a_i & b_i);
            BL_NOR:  y_o = ~(a_i | b_i);
            BL_XNOR: y_o = ~(a_i ^ b_i);
            BL_ANDC: y_o =   a_i & ~b_i;
            BL_ORC:  y_o =   a_i | ~b_i;
            default: y_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/cr_unit.sv
module cr_unit
    import cr_pkg::*;
#(
    parameter int NFIELD = 8,
    parameter int DATA_W = 32
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [5:0]                           op_stb,
    input  logic                                 sum_ovf,
    input  logic [DATA_W-1:0]                    res_val,
    input  logic [$clog2(NFIELD)-1:0]            cmp_fld,
    input  logic [3:0]                           cmp_val,
    input  logic                                 st_ok,
    input  logic [2:0]                           bl_func,
    input  logic [$clog2(NFIELD*4)-1:0]          bl_a,
    input  logic [$clog2(NFIELD*4)-1:0]          bl_b,
    input  logic [$clog2(NFIELD*4)-1:0]          bl_d,
    input  logic [$clog2(NFIELD)-1:0]            mv_src,
    input  logic [$clog2(NFIELD)-1:0]            mv_dst,
    input  logic [NFIELD-1:0]                    ld_mask,
    input  logic [NFIELD*4-1:0]                  ld_val,
    input  logic [$clog2(NFIELD*4)-1:0]          rd_idx,
    output logic [NFIELD*4-1:0]                  cr_word,
    output logic                                 rd_bit
);
    localparam int CR_W   = NFIELD * FIELD_W;
    localparam int IDX_W  = $clog2(CR_W);
    localparam int FSEL_W = $clog2(NFIELD);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(CR_W - 1);

    typedef struct packed {
        logic [CR_W-1:0] cr;
    } state_t;

    state_t state_d, state_q;

    // low bit of field f in the word (field 0 is the top nibble)
    function automatic logic [IDX_W-1:0] fld_lsb(input logic [FSEL_W-1:0] f);
        return IDX_W'((NFIELD - 1 - int'(f)) * FIELD_W);
    endfunction

    // sign classification of the result
    logic [FIELD_W-1:0] sign_field;
    cr_sign_class #(.DATA_W(DATA_W)) u_sign (
        .value_i (res_val),
        .so_i    (sum_ovf),
        .field_o (sign_field)
    );

    // bit-logic operands, MSB-first numbering
    logic bit_a, bit_b, bit_y;
    assign bit_a = state_q.cr[TOP_IDX - bl_a];
    assign bit_b = state_q.cr[TOP_IDX - bl_b];

    cr_bit_logic u_blog (
        .func_i (bl_func),
        .a_i    (bit_a),
        .b_i    (bit_b),
        .y_o    (bit_y)
    );

    // masked-load merge, one slice per field
    logic [CR_W-1:0] load_merged;
    for (genvar f = 0; f < NFIELD; f++) begin : g_load
        localparam int LSB = (NFIELD - 1 - f) * FIELD_W;
        assign load_merged[LSB +: FIELD_W] = ld_mask[NFIELD-1-f]
                                           ? ld_val[LSB +: FIELD_W]
                                           : state_q.cr[LSB +: FIELD_W];
    end

    logic [FIELD_W-1:0] cmp_field;
    logic [FIELD_W-1:0] stc_field;
    logic [FIELD_W-1:0] move_field;
    assign cmp_field  = {cmp_val[FIELD_W-1:1], sum_ovf};
    assign stc_field  = {2'b00, st_ok, sum_ovf};
    assign move_field = state_q.cr[fld_lsb(mv_src) +: FIELD_W];

    always_comb begin
        state_d = state_q;
        if (op_stb[OP_SIGN]) begin
            state_d.cr[fld_lsb('0) +: FIELD_W] = sign_field;
        end else if (op_stb[OP_CMP]) begin
            state_d.cr[fld_lsb(cmp_fld) +: FIELD_W] = cmp_field;
        end else if (op_stb[OP_STC]) begin
            state_d.cr[fld_lsb('0) +: FIELD_W] = stc_field;
        end else if (op_stb[OP_BIT]) begin
            state_d.cr[TOP_IDX - bl_d] = bit_y;
        end else if (op_stb[OP_MOVE]) begin
            state_d.cr[fld_lsb(mv_dst) +: FIELD_W] = move_field;
        end else if (op_stb[OP_LOAD]) begin
            state_d.cr = load_merged;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign cr_word = state_q.cr;
    assign rd_bit  = state_q.cr[TOP_IDX - rd_idx];

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_stb == '0) |=> $stable(cr_word));

    // R3
    sign_one_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_stb[OP_SIGN] |=> ($countones(cr_word[CR_W-1 -: 3]) == 1
                             && cr_word[CR_W-4] == $past(sum_ovf)));

    // R4
    cmp_so_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_stb == 6'b000010) |=> cr_word[fld_lsb($past(cmp_fld))] == $past(sum_ovf));

    // R5
    stc_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_stb == 6'b000100) |=> (cr_word[CR_W-1 -: 2] == 2'b00
                                   && cr_word[CR_W-3] == $past(st_ok)
                                   && $stable(cr_word[CR_W-5:0])));

    // R7
    move_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_stb == 6'b010000) |=> cr_word[fld_lsb($past(mv_dst)) +: FIELD_W]
                                  == $past(cr_word[fld_lsb(mv_src) +: FIELD_W]));

    // R8
    load_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_stb == 6'b100000 && ld_mask == '0) |=> $stable(cr_word));

    // R10
    prio_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_stb[OP_SIGN] && op_stb[OP_LOAD]) |=> $stable(cr_word[CR_W-5:0]));
endmodule

// File: tb/sim_cr_unit.sv
module sim_cr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  op_stb;
    logic        sum_ovf;
    logic [31:0] res_val;
    logic [2:0]  cmp_fld;
    logic [3:0]  cmp_val;
    logic        st_ok;
    logic [2:0]  bl_func;
    logic [4:0]  bl_a, bl_b, bl_d;
    logic [2:0]  mv_src, mv_dst;
    logic [7:0]  ld_mask;
    logic [31:0] ld_val;
    logic [4:0]  rd_idx;
    logic [31:0] cr_word;
    logic        rd_bit;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] expv = 32'h0;

    always #4 clk = ~clk;

    cr_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_stb(op_stb), .sum_ovf(sum_ovf),
        .res_val(res_val), .cmp_fld(cmp_fld), .cmp_val(cmp_val), .st_ok(st_ok),
        .bl_func(bl_func), .bl_a(bl_a), .bl_b(bl_b), .bl_d(bl_d),
        .mv_src(mv_src), .mv_dst(mv_dst), .ld_mask(ld_mask), .ld_val(ld_val),
        .rd_idx(rd_idx), .cr_word(cr_word), .rd_bit(rd_bit)
    );

    function automatic logic [3:0] sign_nib(input logic [31:0] v, input logic so);
        logic [3:0] r;
        if (v[31])          r = 4'b1000;
        else if (v != 0)    r = 4'b0100;
        else                r = 4'b0010;
        r[0] = so;
        return r;
    endfunction

    function automatic logic blf(input logic [2:0] f, input logic a, input logic b);
        case (f)
            3'd0: return a & b;
            3'd1: return a | b;
            3'd2: return a ^ b;
            3'd3: return !(a & b);
            3'd4: return !(a | b);
            3'd5: return a == b;
            3'd6: return a & !b;
            default: return a | !b;
        endcase
    endfunction

    function automatic int winner();
        int w = -1;
        for (int i = 5; i >= 0; i--) if (op_stb[i]) w = i;
        return w;
    endfunction

    function automatic string tag_of();
        int w = winner();
        if ($countones(op_stb) > 1) return "R10";
        case (w)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            3: return "R6";
            4: return "R7";
            5: return "R8";
            default: return "R9";
        endcase
    endfunction

    function automatic logic [31:0] model(input logic [31:0] c);
        logic [31:0] n = c;
        case (winner())
            0: n[31:28] = sign_nib(res_val, sum_ovf);
            1: n[28-4*int'(cmp_fld) +: 4] = {cmp_val[3:1], sum_ovf};
            2: n[31:28] = {2'b00, st_ok, sum_ovf};
            3: n[31-int'(bl_d)] = blf(bl_func, c[31-int'(bl_a)], c[31-int'(bl_b)]);
            4: n[28-4*int'(mv_dst) +: 4] = c[28-4*int'(mv_src) +: 4];
            5: for (int f = 0; f < 8; f++)
                   if (ld_mask[7-f]) n[28-4*f +: 4] = ld_val[28-4*f +: 4];
            default: ;
        endcase
        return n;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s actual %08h expected %08h", tag, act, exp_v);
        end
    endtask

    task automatic idle();
        op_stb = '0; sum_ovf = 0; res_val = '0; cmp_fld = '0; cmp_val = '0;
        st_ok = 0; bl_func = '0; bl_a = '0; bl_b = '0; bl_d = '0;
        mv_src = '0; mv_dst = '0; ld_mask = '0; ld_val = '0;
    endtask

    // apply current inputs for one edge, then check at the falling edge
    task automatic step();
        string t;
        t = tag_of();
        @(posedge clk);
        expv = model(expv);
        @(negedge clk);
        chk(t, cr_word, expv);
        chk("R2", {31'b0, rd_bit}, {31'b0, expv[31-int'(rd_idx)]});
    endtask

    initial begin
        idle();
        rd_idx = 5'd0;
        @(negedge clk);
        op_stb = 6'b100000; ld_mask = 8'hFF; ld_val = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        chk("R1", cr_word, 32'h0);
        idle();
        rst_n = 1'b1;

        // R8: full load of a known pattern, then partial masks
        op_stb = 6'b100000; ld_mask = 8'hFF; ld_val = 32'h1234_5678; step();
        chk("R8", cr_word, 32'h1234_5678);
        op_stb = 6'b100000; ld_mask = 8'h80; ld_val = 32'hA000_000B; rd_idx = 5'd0; step();
        op_stb = 6'b100000; ld_mask = 8'h01; ld_val = 32'hC000_000D; rd_idx = 5'd31; step();
        op_stb = 6'b100000; ld_mask = 8'h00; ld_val = 32'hFFFF_FFFF; step();
        // R9
        idle(); rd_idx = 5'd3; step();
        // R3: negative, positive, zero, with and without SO
        op_stb = 6'b000001; res_val = 32'h8000_0000; sum_ovf = 0; step();
        chk("R3", {28'b0, cr_word[31:28]}, 32'h8);
        op_stb = 6'b000001; res_val = 32'h0000_0001; sum_ovf = 1; step();
        chk("R3", {28'b0, cr_word[31:28]}, 32'h5);
        op_stb = 6'b000001; res_val = 32'h0; sum_ovf = 0; step();
        chk("R3", {28'b0, cr_word[31:28]}, 32'h2);
        // R4: every field, bit 0 forced from SO
        for (int f = 0; f < 8; f++) begin
            idle(); op_stb = 6'b000010; cmp_fld = 3'(f); cmp_val = 4'hF;
            sum_ovf = f[0]; rd_idx = 5'(4*f+3); step();
        end
        // R5
        idle(); op_stb = 6'b000100; st_ok = 1; sum_ovf = 0; step();
        chk("R5", {28'b0, cr_word[31:28]}, 32'h2);
        idle(); op_stb = 6'b000100; st_ok = 0; sum_ovf = 1; step();
        chk("R5", {28'b0, cr_word[31:28]}, 32'h1);
        // R6: every function, destination aliasing a source
        for (int f = 0; f < 8; f++) begin
            idle(); op_stb = 6'b001000; bl_func = 3'(f);
            bl_a = 5'd31; bl_b = 5'd4; bl_d = 5'd31; rd_idx = 5'd31; step();
        end
        // R7: edge fields and self copy
        idle(); op_stb = 6'b010000; mv_src = 3'd0; mv_dst = 3'd7; step();
        idle(); op_stb = 6'b010000; mv_src = 3'd7; mv_dst = 3'd0; step();
        idle(); op_stb = 6'b010000; mv_src = 3'd3; mv_dst = 3'd3; step();
        // R10: same-cycle collisions
        idle(); op_stb = 6'b100001; res_val = 32'h5; ld_mask = 8'hFF; ld_val = 32'h0; step();
        idle(); op_stb = 6'b010010; cmp_fld = 3'd2; cmp_val = 4'h8; mv_src = 3'd0; mv_dst = 3'd2; step();
        idle(); op_stb = 6'b111000; bl_func = 3'd4; bl_d = 5'd10; ld_mask = 8'hFF; step();

        // constrained random
        void'($urandom(32'd20240611));
        for (int n = 0; n < 3000; n++) begin
            int sel = $urandom_range(0, 99);
            if (sel < 5)       op_stb = '0;
            else if (sel < 85) op_stb = 6'(1 << $urandom_range(0, 5));
            else               op_stb = 6'($urandom);
            sum_ovf = 1'($urandom); st_ok = 1'($urandom);
            case ($urandom_range(0, 3))
                0: res_val = 32'h0;
                1: res_val = 32'h8000_0000 | 32'($urandom);
                default: res_val = 32'($urandom) & 32'h7FFF_FFFF;
            endcase
            cmp_fld = 3'($urandom); cmp_val = 4'($urandom);
            bl_func = 3'($urandom); bl_a = 5'($urandom); bl_b = 5'($urandom);
            bl_d = 5'($urandom); mv_src = 3'($urandom); mv_dst = 3'($urandom);
            ld_mask = 8'($urandom); ld_val = 32'($urandom); rd_idx = 5'($urandom);
            step();
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule